// File: doc/BRIEF.md
# SAD Row Engine for Full-Search Block Matching

This block is one row of a systolic motion-estimation array. It holds `N` processing elements (PEs). Each PE keeps one column pixel of the current template row and takes search-area pixels from one of two shared search buses. For every candidate horizontal position, each PE adds one absolute difference to a running partial sum. That partial sum moves one PE to the left per clock. The value leaving the leftmost PE is one template row's contribution to one candidate's sum of absolute differences (SAD).

A buffer of per-candidate partial SADs, with one adder, folds the `N` row contributions of a template block into complete SADs. Each finished SAD is presented with a strobe and its candidate index.

The host drives `run` high and streams the pixels. Each new row start sends a selection pulse across the row from right to left. The pulse moves each PE in turn onto the other search bus and loads that PE's new template pixel. Row streams therefore overlap on the two buses, and consecutive template blocks follow each other with no idle slot.

Top module: `sad_row_engine`

## Requirements
- R1: With `run` high from slot s0, row stream r (r = 0, 1, ...) starts at slot s0 + r*K. Stream r serves template row r mod N of block floor(r/N). For each of the K candidates k, the row adds |c(m,n) - p(m,k+n)| over the N columns n.
- R2: For block b of a run, the SAD of candidate k equals the sum over all N rows and N columns of |c(m,n) - p(m,k+n)|. It appears with `sad_vld` high and `sad_idx` = k in slot s0 + ((b*N + N-1)*K + k + N + 2). Candidates come out in order 0..K-1, one per slot.
- R3: `k_sel` sets the number of candidates K: 0 gives 16, 1 gives 32, 2 or 3 gives 64. It is sampled only while `run` is low. `sad_idx` never reaches K.
- R4: Row streams alternate between the buses, counted from reset: stream number g since reset is read from `sa_bus0` when g is even and from `sa_bus1` when g is odd. Pixel i (0 <= i <= K+N-2) of a stream is on its bus in slot (stream start + i).
- R5: The selection pulse enters the rightmost PE (column 0) at each row start and moves one PE left per slot. Column n loads its template pixel from `tpl_bus` in slot (stream start + n). No two PEs load in the same slot.
- R6: `tpl_bus` outside a PE's load slot, and the bus not owned by any live stream, have no effect on any SAD. Each loaded template pixel stays in use for K slots.
- R7: The first template row of each block overwrites its buffer entry, so no total from an earlier block leaks into a later one.
- R8: Blocks of one run follow each other directly. The SAD stream of block b+1 starts exactly N*K slots after that of block b.
- R9: The worst case, every template pixel 255 against search pixels 0, yields N*N*255 (65280 for N = 16) without wrap.
- R10: `sad_vld` is low during and after reset, and in every slot that carries no finished SAD. In-flight SADs still complete after `run` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while row streams are being issued |
| k_sel | input | 2 | Candidate count select, sampled while `run` is low |
| tpl_bus | input | 8 | Shared template pixel bus |
| sa_bus0 | input | 8 | Search-area bus for even streams |
| sa_bus1 | input | 8 | Search-area bus for odd streams |
| sad_vld | output | 1 | Finished SAD present |
| sad_idx | output | 6 | Candidate index of the finished SAD |
| sad_out | output | 16 | Finished SAD value |

## Verification
The bench drives random junk on the template bus outside each load slot and on whichever search bus no live stream owns. A design that latched at the wrong slot, or read the wrong bus across the overlap of two streams, therefore returns wrong SADs at once.

A saturating block is placed directly before a random block, so the output goes wrong if the first row accumulates into a stale entry or if the split carry path drops a carry. Every K setting is run, the bus parity carries over between runs, and the drain after `run` falls is checked slot by slot. An off-by-one in the ripple or tag pipeline shows up as a misplaced strobe.

// File: rtl/sad_row_pkg.sv
package sad_row_pkg;

    localparam int PIX_W  = 8;
    localparam int SUM_W  = 16;
    localparam int K_MAX  = 64;
    localparam int IDX_W  = $clog2(K_MAX);
    localparam int KCNT_W = IDX_W + 1;

    typedef struct packed {
        logic             vld;
        logic             first;
        logic             last;
        logic [IDX_W-1:0] cand;
    } slot_tag_t;

    function automatic logic [KCNT_W-1:0] k_of_sel(input logic [1:0] sel);
        logic [KCNT_W-1:0] k;
        case (sel)
            2'd0:    k = KCNT_W'(16);
            2'd1:    k = KCNT_W'(32);
            default: k = KCNT_W'(64);
        endcase
        return k;
    endfunction

    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/sad_pe.sv
module sad_pe
    import sad_row_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_in,
    input  logic [PIX_W-1:0] tpl_bus,
    input  logic [PIX_W-1:0] sa_bus0,
    input  logic [PIX_W-1:0] sa_bus1,
    input  logic [PIX_W-1:0] lo_in,
    input  logic [PIX_W-1:0] hi_in,
    output logic [PIX_W-1:0] lo_out,
    output logic [PIX_W-1:0] hi_out
);
    logic [PIX_W-1:0] tpl_q, tpl_eff, pix, dif;
    logic             use1_q, use1;
    logic             cy_q;
    logic [PIX_W:0]   sum_lo;

    always_comb begin
        tpl_eff = sel_in ? tpl_bus : tpl_q;
        use1    = sel_in ? ~use1_q : use1_q;
        pix     = use1 ? sa_bus1 : sa_bus0;
        dif     = abs_diff(tpl_eff, pix);
        sum_lo  = {1'b0, lo_in} + {1'b0, dif};
    end

    // Low byte and its carry are registered; the high byte adds that carry one
    // slot later, so the per-slot path is one 8-bit add behind the subtractor.
    always_ff @(posedge clk) begin
        if (rst) begin
            tpl_q  <= '0;
            use1_q <= 1'b1;
            lo_out <= '0;
            cy_q   <= 1'b0;
            hi_out <= '0;
        end else begin
            tpl_q  <= tpl_eff;
            use1_q <= use1;
            lo_out <= sum_lo[PIX_W-1:0];
            cy_q   <= sum_lo[PIX_W];
            hi_out <= hi_in + {{(PIX_W-1){1'b0}}, cy_q};
        end
    end
endmodule

// File: rtl/sad_row_seq.sv
module sad_row_seq
    import sad_row_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [1:0]        k_sel,
    output logic [N-1:0]      sel_vec,
    output logic [KCNT_W-1:0] k_cur,
    output slot_tag_t         tag_out
);
    localparam int ROW_W = (N > 1) ? $clog2(N) : 1;
    localparam int DEPTH = N + 1;

    logic [IDX_W-1:0] cnt;
    logic [ROW_W-1:0] row;
    logic [N-1:0]     sel_q;
    logic             pulse;
    slot_tag_t        tag_now;
    slot_tag_t        pipe [DEPTH];

    assign pulse   = run && (cnt == '0);
    assign sel_vec = sel_q | {{(N-1){1'b0}}, pulse};

    always_comb begin
        tag_now.vld   = run;
        tag_now.first = (row == '0);
        tag_now.last  = (row == ROW_W'(N-1));
        tag_now.cand  = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            k_cur <= k_of_sel(2'd0);
            cnt   <= '0;
            row   <= '0;
            sel_q <= '0;
        end else begin
            sel_q <= {sel_vec[N-2:0], 1'b0};
            if (!run) begin
                k_cur <= k_of_sel(k_sel);
                cnt   <= '0;
                row   <= '0;
            end else if ({1'b0, cnt} == k_cur - KCNT_W'(1)) begin
                cnt <= '0;
                row <= (row == ROW_W'(N-1)) ? '0 : row + ROW_W'(1);
            end else begin
                cnt <= cnt + IDX_W'(1);
            end
        end
    end

    // The tag rides alongside the partial sum until the row contribution is complete.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tag
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= '0;
            else     pipe[i] <= (i == 0) ? tag_now : pipe[(i == 0) ? 0 : i-1];
        end
    end

    assign tag_out = pipe[DEPTH-1];
endmodule

// File: rtl/sad_row_accum.sv
module sad_row_accum
    import sad_row_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_tag_t        tag,
    input  logic [PIX_W-1:0] lo_last,
    input  logic [PIX_W-1:0] hi_last,
    output logic             sad_vld,
    output logic [IDX_W-1:0] sad_idx,
    output logic [SUM_W-1:0] sad_out
);
    logic [SUM_W-1:0] part [K_MAX];
    logic [PIX_W-1:0] lo_d;
    logic [SUM_W-1:0] contrib, base, total;

    always_comb begin
        contrib = {hi_last, lo_d};
        base    = tag.first ? '0 : part[tag.cand];
        total   = base + contrib;
    end

    always_ff @(posedge clk) begin
        if (tag.vld) part[tag.cand] <= total;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_d    <= '0;
            sad_vld <= 1'b0;
            sad_idx <= '0;
            sad_out <= '0;
        end else begin
            lo_d    <= lo_last;
            sad_vld <= tag.vld && tag.last;
            if (tag.vld && tag.last) begin
                sad_idx <= tag.cand;
                sad_out <= total;
            end
        end
    end
endmodule

// File: rtl/sad_row_engine.sv
module sad_row_engine
    import sad_row_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [1:0]       k_sel,
    input  logic [7:0]       tpl_bus,
    input  logic [7:0]       sa_bus0,
    input  logic [7:0]       sa_bus1,
    output logic             sad_vld,
    output logic [5:0]       sad_idx,
    output logic [15:0]      sad_out
);
    logic [N-1:0]      sel_vec;
    logic [KCNT_W-1:0] k_cur;
    slot_tag_t         tag;
    logic [PIX_W-1:0]  lo_w [N+1];
    logic [PIX_W-1:0]  hi_w [N+1];

    assign lo_w[0] = '0;
    assign hi_w[0] = '0;

    sad_row_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .k_sel   (k_sel),
        .sel_vec (sel_vec),
        .k_cur   (k_cur),
        .tag_out (tag)
    );

    // Column 0 is the rightmost PE; partial sums travel toward higher columns.
    for (genvar n = 0; n < N; n++) begin : g_pe
        sad_pe u_pe (
            .clk     (clk),
            .rst     (rst),
            .sel_in  (sel_vec[n]),
            .tpl_bus (tpl_bus),
            .sa_bus0 (sa_bus0),
            .sa_bus1 (sa_bus1),
            .lo_in   (lo_w[n]),
            .hi_in   (hi_w[n]),
            .lo_out  (lo_w[n+1]),
            .hi_out  (hi_w[n+1])
        );
    end

    sad_row_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .tag     (tag),
        .lo_last (lo_w[N]),
        .hi_last (hi_w[N]),
        .sad_vld (sad_vld),
        .sad_idx (sad_idx),
        .sad_out (sad_out)
    );
endmodule

// File: rtl/sad_row_chk.sv
module sad_row_chk
    import sad_row_pkg::*;
#(
    parameter int N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      sel_vec,
    input logic [KCNT_W-1:0] k_cur,
    input logic              sad_vld,
    input logic [IDX_W-1:0]  sad_idx,
    input logic [SUM_W-1:0]  sad_out
);
    // R5
    one_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_vec));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sad_vld && $past(sad_vld)) |->
        (sad_idx == ((({1'b0, $past(sad_idx)} + KCNT_W'(1)) == k_cur)
                     ? IDX_W'(0) : $past(sad_idx) + IDX_W'(1))));

    // R2
    idx_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sad_vld) |-> (sad_idx == '0));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        sad_vld |-> ({1'b0, sad_idx} < k_cur));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        sad_vld |-> (int'(sad_out) <= N * N * 255));
endmodule

bind sad_row_engine sad_row_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_vec (sel_vec),
    .k_cur   (k_cur),
    .sad_vld (sad_vld),
    .sad_idx (sad_idx),
    .sad_out (sad_out)
);

// File: tb/sad_row_engine_bench.sv
module sad_row_engine_bench;
    localparam int N  = 16;
    localparam int WM = 64 + N;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [1:0] k_sel = 2'd0;
    logic [7:0] tpl_bus = '0, sa_bus0 = '0, sa_bus1 = '0;
    logic       sad_vld;
    logic [5:0] sad_idx;
    logic [15:0] sad_out;

    always #10 clk = ~clk;

    sad_row_engine #(.N(N)) u_sad_row_engine (
        .clk(clk), .rst(rst), .run(run), .k_sel(k_sel),
        .tpl_bus(tpl_bus), .sa_bus0(sa_bus0), .sa_bus1(sa_bus1),
        .sad_vld(sad_vld), .sad_idx(sad_idx), .sad_out(sad_out)
    );

    int    tp [0:3][0:N-1][0:N-1];
    int    sp [0:3][0:N-1][0:WM-1];
    int    exp_sad [int];
    int    exp_idx [int];
    string exp_tag [int];
    int    cyc = 0, checks = 0, errors = 0, gr = 0;
    bit    done = 1'b0;

    // Reference: every slot either carries one expected SAD or no strobe (R10).
    task automatic tick();
        @(negedge clk);
        cyc++;
        checks++;
        if (exp_sad.exists(cyc)) begin
            if (!sad_vld || sad_out != 16'(exp_sad[cyc]) || sad_idx != 6'(exp_idx[cyc])) begin
                errors++;
                $display("FAIL %s slot %0d: vld=%0b idx=%0d sad=%0d expected vld=1 idx=%0d sad=%0d",
                         exp_tag[cyc], cyc, sad_vld, sad_idx, sad_out, exp_idx[cyc], exp_sad[cyc]);
            end
        end else if (sad_vld) begin
            errors++;
            $display("FAIL R10 slot %0d: vld=1 idx=%0d sad=%0d expected vld=0", cyc, sad_idx, sad_out);
        end
    endtask

    // pat: 0 random, 1 worst case (R9)
    task automatic fill_block(input int b, input int pat);
        for (int m = 0; m < N; m++) begin
            for (int n = 0; n < N; n++) tp[b][m][n] = (pat == 1) ? 255 : int'($urandom_range(0, 255));
            for (int i = 0; i < WM; i++) sp[b][m][i] = (pat == 1) ? 0 : int'($urandom_range(0, 255));
        end
    endtask

    task automatic run_period(input int ks, input int nb, input string tags[4]);
        int k_n, s0, total;
        k_n = (ks == 0) ? 16 : (ks == 1) ? 32 : 64;       // R3 encoding
        run = 1'b0;
        k_sel = 2'(ks);
        tick();
        tick();
        s0 = cyc + 1;
        // R2 / R8 timing: block b candidate k in slot s0 + (b*N+N-1)*K + k + N + 2
        for (int b = 0; b < nb; b++)
            for (int k = 0; k < k_n; k++) begin
                int s = 0;
                for (int m = 0; m < N; m++)
                    for (int n = 0; n < N; n++) begin
                        int d = tp[b][m][n] - sp[b][m][k+n];
                        s += (d < 0) ? -d : d;
                    end
                exp_sad[s0 + (b*N + N-1)*k_n + k + N + 2] = s;
                exp_idx[s0 + (b*N + N-1)*k_n + k + N + 2] = k;
                exp_tag[s0 + (b*N + N-1)*k_n + k + N + 2] = tags[b];
            end
        total = nb * N * k_n;
        for (int t = 0; t < total + N + 6; t++) begin
            int v0, v1, tv, j, n;
            tick();
            run = (t < total);
            // R6: junk wherever no live stream or load slot applies
            v0 = int'($urandom_range(0, 255));
            v1 = int'($urandom_range(0, 255));
            tv = int'($urandom_range(0, 255));
            // R4: two live streams at most, on alternating buses
            for (int dj = -1; dj <= 0; dj++) begin
                int i;
                j = t / k_n + dj;
                i = t - j * k_n;
                if (j >= 0 && j < nb*N && i >= 0 && i <= k_n + N - 2) begin
                    if (((gr + j) % 2) == 0) v0 = sp[j/N][j%N][i];
                    else                     v1 = sp[j/N][j%N][i];
                end
            end
            // R5: column n loads in slot stream start + n
            j = t / k_n;
            n = t % k_n;
            if (j < nb*N && n < N) tv = tp[j/N][j%N][n];
            sa_bus0 = 8'(v0);
            sa_bus1 = 8'(v1);
            tpl_bus = 8'(tv);
        end
        gr += nb * N;
    endtask

    initial begin
        string t1[4];
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick();   // R10 reset state
        rst = 1'b0;
        // R1 random, R9 saturating, R7 random right after saturating block
        fill_block(0, 0); fill_block(1, 1); fill_block(2, 0);
        t1 = '{"R1 R2 R4 R5 R6", "R9 R8", "R7 R8", ""};
        run_period(0, 3, t1);
        // R3: K = 32, bus parity continues from previous run (R4)
        fill_block(0, 0); fill_block(1, 0);
        t1 = '{"R3 K=32", "R3 R8 K=32", "", ""};
        run_period(1, 2, t1);
        fill_block(0, 1); fill_block(1, 0);
        t1 = '{"R3 R9 K=64", "R3 R7 K=64", "", ""};
        run_period(2, 2, t1);
        fill_block(0, 0);
        t1 = '{"R3 sel3 K=64", "", "", ""};
        run_period(3, 1, t1);
        for (int i = 0; i < 5; i++) tick();   // R10 idle after drain
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule